// File: doc/BRIEF.md
# Transmit Power and Lock Sequencer

This block controls when the transmit side of a serial video link wakes up, when it may drive the line, and when it must go quiet. A power request input and an input-supply-good flag together decide whether the link is allowed on. While either is low, the clock generator, the line termination and the line driver all stay disabled.

Once the link is allowed on, the block enables the clock generator and the termination at once. It then counts a fixed number of parallel-clock cycles before it lets the driver run. During that count the termination pulls both line wires together, so the differential voltage stays at zero. A 2-bit range select tells the block which parallel-clock band is in use. The block reports that band in kHz and the matching serial bit-rate band in Mbit/s, which is twenty times the clock. Changing the range while the link is on discards any lock already reached and starts the count again.

Top module: `pds_power_seq`

## Requirements
- R1: While `pwr_on_req` is low, `pll_en`, `term_en`, `drv_en` and `locked` are all 0 in the same cycle, with no clock edge needed.
- R2: After the first clock edge that sees `pwr_on_req` and `vin_ok` both high, `pll_en` and `term_en` are 1 and `drv_en` is 0.
- R3: `drv_en` and `locked` rise exactly LOCK_CYCLES (default 17100) clock edges after the edge that began locking, and not one edge earlier.
- R4: For the whole locking interval, `term_en` is 1 while `drv_en` is 0. `drv_en` is never 1 unless `term_en` and `pll_en` are also 1.
- R5: A low `vin_ok` acts exactly like a low `pwr_on_req`: every enable drops in the same cycle, even if `pwr_on_req` stays high.
- R6: Any loss of power request or supply returns the block to the off state and clears the count. A later power-up needs the full LOCK_CYCLES again.
- R7: A change of `rng_sel` seen at an edge while locking or running drops `drv_en` and `locked` at that edge. Lock then takes a full LOCK_CYCLES from that edge.
- R8: The clock band follows `rng_sel` as follows. Code 0 gives 2500 to 5000 kHz. Code 1 gives 5000 to 10000 kHz. Code 2 gives 10000 to 20000 kHz. Code 3 gives 20000 to 42000 kHz.
- R9: Each serial-rate bound equals twenty times the matching clock bound, in Mbit/s. The bounds are 50/100, 100/200, 200/400 and 400/840.
- R10: `locked` is 1 only in the run state, and it always equals `drv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock; the lock count advances on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | High requests the powered state |
| vin_ok | input | 1 | High when the input-buffer supply is present |
| rng_sel | input | 2 | Parallel-clock band select |
| pll_en | output | 1 | Clock generator enable |
| term_en | output | 1 | Line termination switched in |
| drv_en | output | 1 | Line driver enable |
| locked | output | 1 | Lock status, high in the run state only |
| clk_lo_khz | output | 16 | Lower clock bound of the selected band |
| clk_hi_khz | output | 16 | Upper clock bound of the selected band |
| rate_lo_mbps | output | 10 | Lower serial rate bound |
| rate_hi_mbps | output | 10 | Upper serial rate bound |

## Verification
A count that is off by one, or that is not cleared, shows up as `drv_en` rising one edge early or late. The bench therefore samples both the cycle before the expected lock and the cycle of it. A stale range register, or a state machine that misses a restart, leaves `drv_en` high after a range change, so the bench looks at the edge right after the change. If the power gating is done only by state, the enables would still be high in the cycle where power-down or supply loss happens, so the bench checks that same cycle.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_LOCK = 2'd1,
    PS_RUN  = 2'd2
  } pstate_t;

  localparam int unsigned BASE_KHZ      = 2500;
  localparam int unsigned TOP_KHZ       = 42000;
  localparam int unsigned BITS_PER_WORD = 20;
  localparam int unsigned KHZ_W         = 16;
  localparam int unsigned MBPS_W        = 10;

  // lower edge of band: base doubled per code step
  function automatic logic [KHZ_W-1:0] band_lo_khz(input logic [1:0] s);
    return KHZ_W'(BASE_KHZ << s);
  endfunction

  // upper edge: next band start, except the top band which stops at TOP_KHZ
  function automatic logic [KHZ_W-1:0] band_hi_khz(input logic [1:0] s);
    if (s == 2'd3) return KHZ_W'(TOP_KHZ);
    return KHZ_W'(BASE_KHZ << (int'(s) + 1));
  endfunction

  // serial rate in Mbit/s from a clock in kHz
  function automatic logic [MBPS_W-1:0] khz_to_mbps(input logic [KHZ_W-1:0] k);
    return MBPS_W'((int'(k) * BITS_PER_WORD) / 1000);
  endfunction
endpackage

// File: rtl/pds_range_decode.sv
module pds_range_decode
  import pds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rng_sel,
  output logic              rng_chg,
  output logic [KHZ_W-1:0]  lo_khz,
  output logic [KHZ_W-1:0]  hi_khz,
  output logic [MBPS_W-1:0] lo_mbps,
  output logic [MBPS_W-1:0] hi_mbps
);
  logic [1:0] rng_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rng_q <= 2'd0;
    else        rng_q <= rng_sel;
  end

  assign rng_chg = (rng_sel != rng_q);
  assign lo_khz  = band_lo_khz(rng_sel);
  assign hi_khz  = band_hi_khz(rng_sel);
  assign lo_mbps = khz_to_mbps(lo_khz);
  assign hi_mbps = khz_to_mbps(hi_khz);

  // R8: band upper bound always above lower bound
  p_band_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_khz > lo_khz);
  // R9: rate bounds keep the same ordering as the clock bounds
  p_rate_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_mbps > lo_mbps);
endmodule

// File: rtl/pds_lock_counter.sv
module pds_lock_counter #(
  parameter int unsigned LOCK_CYCLES = 17100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int unsigned CW   = $clog2(LOCK_CYCLES + 1);
  localparam int unsigned LAST = LOCK_CYCLES - 1;

  logic [CW-1:0] cnt;

  assign done = en && (cnt == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (en && !done)     cnt <= cnt + 1'b1;
  end

  // R3: count never passes the terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LAST));
  // R6: a clear request leaves the count at zero
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/pds_ctrl_fsm.sv
module pds_ctrl_fsm
  import pds_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    eff_on,
  input  logic    rng_chg,
  input  logic    done,
  output pstate_t state
);
  pstate_t nxt;

  always_comb begin
    nxt = state;
    if (!eff_on) nxt = PS_OFF;
    else begin
      unique case (state)
        PS_OFF:  nxt = PS_LOCK;
        PS_LOCK: if (!rng_chg && done) nxt = PS_RUN;
        PS_RUN:  if (rng_chg) nxt = PS_LOCK;
        default: nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= nxt;
  end

  // R3: run state is entered only from a finished count
  p_run_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_RUN) ##1 (state == PS_RUN) |-> $past(done));
  // R6: loss of power permission lands in off
  p_off_on_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_on |=> (state == PS_OFF));
  // R7: a range change while active goes back to locking
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_on && rng_chg && state != PS_OFF) |=> (state == PS_LOCK));
endmodule

// File: rtl/pds_power_seq.sv
module pds_power_seq
  import pds_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 17100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_req,
  input  logic              vin_ok,
  input  logic [1:0]        rng_sel,
  output logic              pll_en,
  output logic              term_en,
  output logic              drv_en,
  output logic              locked,
  output logic [KHZ_W-1:0]  clk_lo_khz,
  output logic [KHZ_W-1:0]  clk_hi_khz,
  output logic [MBPS_W-1:0] rate_lo_mbps,
  output logic [MBPS_W-1:0] rate_hi_mbps
);
  logic    eff_on;
  logic    rng_chg;
  logic    cnt_done;
  logic    cnt_clr;
  logic    cnt_en;
  pstate_t state;

  // missing input supply forces the power request low
  assign eff_on  = pwr_on_req && vin_ok;
  assign cnt_en  = (state == PS_LOCK) && eff_on && !rng_chg;
  assign cnt_clr = (state != PS_LOCK) || !eff_on || rng_chg;

  pds_range_decode u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .rng_sel (rng_sel),
    .rng_chg (rng_chg),
    .lo_khz  (clk_lo_khz),
    .hi_khz  (clk_hi_khz),
    .lo_mbps (rate_lo_mbps),
    .hi_mbps (rate_hi_mbps)
  );

  pds_lock_counter #(.LOCK_CYCLES(LOCK_CYCLES)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .done  (cnt_done)
  );

  pds_ctrl_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .eff_on  (eff_on),
    .rng_chg (rng_chg),
    .done    (cnt_done),
    .state   (state)
  );

  // enables gated by eff_on so power-down acts without waiting for an edge
  assign pll_en  = eff_on && (state != PS_OFF);
  assign term_en = eff_on && (state != PS_OFF);
  assign drv_en  = eff_on && (state == PS_RUN);
  assign locked  = eff_on && (state == PS_RUN);

  // R1: power-down silences every control
  p_pd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_req |-> !(pll_en || term_en || drv_en || locked));
  // R5: supply loss behaves as power-down
  p_supply_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vin_ok |-> !(pll_en || term_en || drv_en || locked));
  // R4: driver never runs without termination and clock generator
  p_drv_needs_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (term_en && pll_en));
  // R10: lock status tracks the driver enable
  p_lock_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked == drv_en);
endmodule

// File: tb/pds_power_seq_test.sv
`timescale 1ns/1ps
module pds_power_seq_test;
  localparam int unsigned N = 17100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on_req = 1'b0;
  logic        vin_ok = 1'b1;
  logic [1:0]  rng_sel = 2'd0;
  logic        pll_en, term_en, drv_en, locked;
  logic [15:0] clk_lo_khz, clk_hi_khz;
  logic [9:0]  rate_lo_mbps, rate_hi_mbps;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         at;
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pds_power_seq uut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .vin_ok(vin_ok),
    .rng_sel(rng_sel), .pll_en(pll_en), .term_en(term_en), .drv_en(drv_en),
    .locked(locked), .clk_lo_khz(clk_lo_khz), .clk_hi_khz(clk_hi_khz),
    .rate_lo_mbps(rate_lo_mbps), .rate_hi_mbps(rate_hi_mbps)
  );

  // monitor: compare queued expectations {pll,term,drv,locked} at negedge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic [3:0] act;
      it = sb.pop_front();
      act = {pll_en, term_en, drv_en, locked};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d actual %b expected %b", it.tag, cyc, act, it.exp);
      end
    end
  end

  task automatic expect_at(input int at, input logic [3:0] e, input string tag);
    item_t it;
    it.at = at; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check_band(input logic [1:0] s);
    int lo, hi;
    lo = 2500 * (1 << s);
    hi = (s == 2'd3) ? 42000 : 2500 * (1 << (s + 1));
    rng_sel = s;
    #1;
    checks++;
    if (clk_lo_khz !== 16'(lo) || clk_hi_khz !== 16'(hi)) begin
      errors++;
      $display("FAIL R8 sel %0d actual %0d/%0d expected %0d/%0d", s,
               clk_lo_khz, clk_hi_khz, lo, hi);
    end
    checks++;
    if (rate_lo_mbps !== 10'(lo / 50) || rate_hi_mbps !== 10'(hi / 50)) begin
      errors++;
      $display("FAIL R9 sel %0d actual %0d/%0d expected %0d/%0d", s,
               rate_lo_mbps, rate_hi_mbps, lo / 50, hi / 50);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    expect_at(cyc, 4'b0000, "R1 reset state");
    for (int s = 0; s < 4; s++) check_band(2'(s));
    rng_sel = 2'd2;
    wait_until(cyc + 2);

    // power-up and first lock
    c0 = cyc;
    pwr_on_req = 1'b1;
    expect_at(c0,         4'b0000, "R2 same cycle still off");
    expect_at(c0 + 1,     4'b1100, "R2 enables after edge");
    expect_at(c0 + 500,   4'b1100, "R4 mid locking");
    expect_at(c0 + N,     4'b1100, "R3 one edge before lock");
    expect_at(c0 + N + 1, 4'b1111, "R3 R10 lock reached");
    wait_until(c0 + N + 5);

    // power-down acts in the same cycle
    c0 = cyc;
    pwr_on_req = 1'b0;
    expect_at(c0,     4'b0000, "R1 immediate power-down");
    expect_at(c0 + 2, 4'b0000, "R1 stays off");
    wait_until(c0 + 3);

    // partial lock, brief drop, full recount
    c0 = cyc;
    pwr_on_req = 1'b1;
    expect_at(c0 + 100, 4'b0000, "R6 drop cycle");
    wait_until(c0 + 100);
    pwr_on_req = 1'b0;
    wait_until(c0 + 101);
    c0 = cyc;
    pwr_on_req = 1'b1;
    expect_at(c0 + N - 99, 4'b1100, "R6 no credit for old count");
    expect_at(c0 + N,      4'b1100, "R6 before relock");
    expect_at(c0 + N + 1,  4'b1111, "R6 relock");
    wait_until(c0 + N + 5);

    // range change in run restarts
    c0 = cyc;
    rng_sel = 2'd3;
    expect_at(c0,         4'b1111, "R7 change cycle");
    expect_at(c0 + 1,     4'b1100, "R7 lock dropped");
    expect_at(c0 + N,     4'b1100, "R7 before relock");
    expect_at(c0 + N + 1, 4'b1111, "R7 relock");
    wait_until(c0 + N + 5);

    // supply loss
    c0 = cyc;
    vin_ok = 1'b0;
    expect_at(c0,     4'b0000, "R5 supply loss immediate");
    expect_at(c0 + 2, 4'b0000, "R5 supply loss held");
    wait_until(c0 + 2);
    c0 = cyc;
    vin_ok = 1'b1;
    expect_at(c0 + 1,     4'b1100, "R5 restart locking");
    expect_at(c0 + N,     4'b1100, "R5 before relock");
    expect_at(c0 + N + 1, 4'b1111, "R5 relock");
    wait_until(c0 + N + 3);

    @(negedge clk); #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule